// File: doc/BRIEF.md
# Instruction Decoder and Pipeline Control Unit

This block is the decode stage of a small in-order pipeline. It accepts a 32-bit instruction word and, in the same cycle, produces the control flags that steer the later stages: which register field names the destination, whether the ALU's second operand is a register or the immediate, the ALU operation, the data memory read and write strobes, the register file write enable, the memory-to-register writeback select, and the branch and jump flags. It also breaks the word into its operand fields so that the register file, the immediate extender and the jump logic can pick them up directly.

Three word layouts are recognised. The register layout carries operand and destination indices, a shift amount and a function code. The immediate layout carries two register indices and a 16-bit value. The jump layout carries a 26-bit target. The opcode and function-code assignments belong to this project and do not follow the common industry map. Any word that matches no listed encoding is turned into a no-op, so that it cannot change architectural state.

The unit has no storage and no handshake. The field and control outputs depend only on the present `instr` value. Pipeline registers before and after it belong to the surrounding stage and are outside this block, so no back-pressure rules apply here.

Top module: `instr_decoder`

## Requirements
- R1: The field outputs come from fixed bit positions of `instr`: opcode [31:26], `rs_idx` [25:21], `rt_idx` [20:16], `rd_idx` [15:11], `shamt` [10:6], function code [5:0], `imm` [15:0] and `jump_target` [25:0]. They are extracted for every word, whatever its opcode.
- R2: With opcode 000000, the function codes 110000, 110001, 110010, 110011, 110100, 110101 and 110110 select the ALU operations add (0), subtract (1), and (2), or (3), nor (4), shift left (5) and shift right (6), using the `alu_op` encoding given here.
- R3: A valid register-layout word sets `reg_dst_rd`=1 and `reg_wr`=1. It clears `alu_src_imm`, `mem_rd`, `mem_wr`, `mem_to_reg`, `branch` and `jump`.
- R4: Opcodes 001000, 001001 and 001010 set `alu_src_imm`=1 and `reg_wr`=1 with `reg_dst_rd`=0. Their `alu_op` values are add (0), and (2) and or (3). All memory, branch and jump flags stay 0.
- R5: Opcode 010000 (load) sets `alu_src_imm`, `mem_rd`, `mem_to_reg` and `reg_wr` to 1. Its `alu_op` is add (0). `mem_wr`, `reg_dst_rd`, `branch` and `jump` stay 0.
- R6: Opcode 010001 (store) sets `alu_src_imm` and `mem_wr` to 1. Its `alu_op` is add (0). `reg_wr`, `mem_rd`, `mem_to_reg`, `branch` and `jump` stay 0.
- R7: Opcode 000100 (branch on equal) sets `branch`=1 with `alu_op` subtract (1) and `alu_src_imm`=0. No write flag is set and `jump` stays 0.
- R8: Opcode 000010 (jump) sets `jump`=1 only. Every write, memory and branch flag stays 0.
- R9: Any opcode not listed above, and opcode 000000 with an unlisted function code, give the no-op: all single-bit flags 0 and `alu_op` 0.
- R10: The outputs are combinational. A change on `instr` appears on every output with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source, or immediate-layout destination, index |
| rd_idx | output | 5 | Register-layout destination index |
| shamt | output | 5 | Shift amount field |
| imm | output | 16 | Raw 16-bit immediate field |
| jump_target | output | 26 | Raw jump target field |
| reg_dst_rd | output | 1 | 1: destination is `rd_idx`; 0: destination is `rt_idx` |
| alu_src_imm | output | 1 | 1: ALU second operand is the immediate |
| alu_op | output | 3 | ALU operation code (0 add … 6 shift right) |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| reg_wr | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | 1: write back the memory data, not the ALU result |
| branch | output | 1 | Conditional branch on equal |
| jump | output | 1 | Unconditional jump |

## Verification
The bench sweeps all 64 opcodes and all 64 function codes under opcode 000000. This catches a decoder that leaves an unlisted encoding with a write or branch flag set, which would let a stray word corrupt registers or memory. The branch and jump opcodes differ in only two bits, so the bench checks each of them against the other's flag; a decoder that confuses them would jump on a compare or compare on a jump. Store and branch are checked for a clear `reg_wr`; a wrong decode there writes garbage into the register file. The field checks use words whose opcode is not register layout, so they expose a splitter that gates fields by format or uses shifted bit positions.

// File: rtl/idec_pkg.sv
package idec_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_NOR = 3'd4,
    ALU_SLL = 3'd5,
    ALU_SRL = 3'd6
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst_rd;
    logic    alu_src_imm;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    reg_wr;
    logic    mem_to_reg;
    logic    branch;
    logic    jump;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    reg_dst_rd: 1'b0, alu_src_imm: 1'b0, alu_op: ALU_ADD,
    mem_rd: 1'b0, mem_wr: 1'b0, reg_wr: 1'b0,
    mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0
  };

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_JMP   = 6'b000010;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_ANDI  = 6'b001001;
  localparam logic [5:0] OPC_ORI   = 6'b001010;
  localparam logic [5:0] OPC_LOAD  = 6'b010000;
  localparam logic [5:0] OPC_STORE = 6'b010001;

  localparam logic [5:0] FN_ADD = 6'b110000;
  localparam logic [5:0] FN_SUB = 6'b110001;
  localparam logic [5:0] FN_AND = 6'b110010;
  localparam logic [5:0] FN_OR  = 6'b110011;
  localparam logic [5:0] FN_NOR = 6'b110100;
  localparam logic [5:0] FN_SLL = 6'b110101;
  localparam logic [5:0] FN_SRL = 6'b110110;

endpackage

// File: rtl/idec_fields.sv
module idec_fields #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OPC_W   = 6,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned SHAMT_W = 5,
  parameter int unsigned FUNCT_W = 6
) (
  input  logic [INSTR_W-1:0] word_i,
  output logic [OPC_W-1:0]   opcode_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [SHAMT_W-1:0] shamt_o,
  output logic [FUNCT_W-1:0] funct_o,
  output logic [INSTR_W-OPC_W-2*REG_W-1:0] imm_o,
  output logic [INSTR_W-OPC_W-1:0]         target_o
);
  localparam int unsigned OPC_LSB   = INSTR_W - OPC_W;
  localparam int unsigned RS_LSB    = OPC_LSB - REG_W;
  localparam int unsigned RT_LSB    = RS_LSB - REG_W;
  localparam int unsigned RD_LSB    = RT_LSB - REG_W;
  localparam int unsigned SHAMT_LSB = RD_LSB - SHAMT_W;
  localparam int unsigned IMM_W     = RT_LSB;
  localparam int unsigned TGT_W     = OPC_LSB;

  // The register layout must fill the word exactly.
  initial begin
    a_r1_layout_fits: assert (SHAMT_LSB == FUNCT_W);
  end

  always_comb begin
    opcode_o = word_i[INSTR_W-1 -: OPC_W];
    rs_o     = word_i[RS_LSB +: REG_W];
    rt_o     = word_i[RT_LSB +: REG_W];
    rd_o     = word_i[RD_LSB +: REG_W];
    shamt_o  = word_i[SHAMT_LSB +: SHAMT_W];
    funct_o  = word_i[FUNCT_W-1:0];
    imm_o    = word_i[IMM_W-1:0];
    target_o = word_i[TGT_W-1:0];
  end

  // The immediate is the low part of the register-layout field group.
  always_comb begin
    if (!$isunknown(word_i)) begin
      a_r1_imm_overlays_rd: assert (imm_o[IMM_W-1 -: REG_W] == rd_o);
      a_r1_target_overlays_rs: assert (target_o[TGT_W-1 -: REG_W] == rs_o);
    end
  end
endmodule

// File: rtl/idec_funct.sv
module idec_funct
  import idec_pkg::*;
#(
  parameter int unsigned FUNCT_W = 6
) (
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_op_e            op_o,
  output logic               legal_o
);
  always_comb begin
    legal_o = 1'b1;
    op_o    = ALU_ADD;
    unique case (funct_i)
      FN_ADD:  op_o = ALU_ADD;
      FN_SUB:  op_o = ALU_SUB;
      FN_AND:  op_o = ALU_AND;
      FN_OR:   op_o = ALU_OR;
      FN_NOR:  op_o = ALU_NOR;
      FN_SLL:  op_o = ALU_SLL;
      FN_SRL:  op_o = ALU_SRL;
      default: legal_o = 1'b0;
    endcase
  end

  // An illegal function code must not carry an operation other than add.
  always_comb begin
    if (!$isunknown(funct_i)) begin
      a_r9_illegal_funct_op: assert (legal_o || op_o == ALU_ADD);
    end
  end
endmodule

// File: rtl/idec_main.sv
module idec_main
  import idec_pkg::*;
#(
  parameter int unsigned OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             funct_legal_i,
  input  alu_op_e          funct_op_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = CTRL_NOP;
    case (opcode_i)
      OPC_REG: begin
        if (funct_legal_i) begin
          ctrl_o.reg_dst_rd = 1'b1;
          ctrl_o.reg_wr     = 1'b1;
          ctrl_o.alu_op     = funct_op_i;
        end
      end
      OPC_ADDI, OPC_ANDI, OPC_ORI: begin
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.reg_wr      = 1'b1;
        ctrl_o.alu_op      = (opcode_i == OPC_ANDI) ? ALU_AND :
                             (opcode_i == OPC_ORI)  ? ALU_OR  : ALU_ADD;
      end
      OPC_LOAD: begin
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_rd      = 1'b1;
        ctrl_o.mem_to_reg  = 1'b1;
        ctrl_o.reg_wr      = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_wr      = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OPC_JMP: begin
        ctrl_o.jump = 1'b1;
      end
      default: ctrl_o = CTRL_NOP;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode_i) && !$isunknown(funct_legal_i)) begin
      // R3: the rd destination only comes from the register layout
      a_r3_rd_only_reg_layout: assert (!ctrl_o.reg_dst_rd || opcode_i == OPC_REG);
      // R5/R6: never read and write memory together; writeback of memory needs a read
      a_r5_mem_excl: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr));
      a_r5_m2r_needs_read: assert (!ctrl_o.mem_to_reg || ctrl_o.mem_rd);
      // R7/R8: control transfers write nothing
      a_r7_flow_no_write: assert (!(ctrl_o.branch || ctrl_o.jump) ||
                                  !(ctrl_o.reg_wr || ctrl_o.mem_wr || ctrl_o.mem_rd));
      a_r8_branch_jump_excl: assert ($countones({ctrl_o.branch, ctrl_o.jump}) <= 1);
      // R9: a rejected function code leaves no side effect
      a_r9_bad_funct_quiet: assert (opcode_i != OPC_REG || funct_legal_i ||
                                    ctrl_o == CTRL_NOP);
    end
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OPC_W   = 6,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned SHAMT_W = 5,
  parameter int unsigned FUNCT_W = 6
) (
  input  logic [INSTR_W-1:0]               instr,
  output logic [REG_W-1:0]                 rs_idx,
  output logic [REG_W-1:0]                 rt_idx,
  output logic [REG_W-1:0]                 rd_idx,
  output logic [SHAMT_W-1:0]               shamt,
  output logic [INSTR_W-OPC_W-2*REG_W-1:0] imm,
  output logic [INSTR_W-OPC_W-1:0]         jump_target,
  output logic                             reg_dst_rd,
  output logic                             alu_src_imm,
  output logic [2:0]                       alu_op,
  output logic                             mem_rd,
  output logic                             mem_wr,
  output logic                             reg_wr,
  output logic                             mem_to_reg,
  output logic                             branch,
  output logic                             jump
);
  logic [OPC_W-1:0]   opcode;
  logic [FUNCT_W-1:0] funct;
  alu_op_e            fn_op;
  logic               fn_legal;
  ctrl_t              ctrl;

  idec_fields #(
    .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W),
    .SHAMT_W(SHAMT_W), .FUNCT_W(FUNCT_W)
  ) u_fields (
    .word_i   (instr),
    .opcode_o (opcode),
    .rs_o     (rs_idx),
    .rt_o     (rt_idx),
    .rd_o     (rd_idx),
    .shamt_o  (shamt),
    .funct_o  (funct),
    .imm_o    (imm),
    .target_o (jump_target)
  );

  idec_funct #(.FUNCT_W(FUNCT_W)) u_funct (
    .funct_i (funct),
    .op_o    (fn_op),
    .legal_o (fn_legal)
  );

  idec_main #(.OPC_W(OPC_W)) u_main (
    .opcode_i      (opcode),
    .funct_legal_i (fn_legal),
    .funct_op_i    (fn_op),
    .ctrl_o        (ctrl)
  );

  always_comb begin
    reg_dst_rd  = ctrl.reg_dst_rd;
    alu_src_imm = ctrl.alu_src_imm;
    alu_op      = ctrl.alu_op;
    mem_rd      = ctrl.mem_rd;
    mem_wr      = ctrl.mem_wr;
    reg_wr      = ctrl.reg_wr;
    mem_to_reg  = ctrl.mem_to_reg;
    branch      = ctrl.branch;
    jump        = ctrl.jump;
  end

  // R4: an immediate operand never selects the rd destination
  always_comb begin
    if (!$isunknown(instr)) begin
      a_r4_imm_not_rd: assert (!(alu_src_imm && reg_dst_rd));
    end
  end
endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  rs_idx, rt_idx, rd_idx, shamt;
  logic [15:0] imm;
  logic [25:0] jump_target;
  logic        reg_dst_rd, alu_src_imm, mem_rd, mem_wr, reg_wr, mem_to_reg, branch, jump;
  logic [2:0]  alu_op;

  instr_decoder u_dut (
    .instr(instr), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx),
    .shamt(shamt), .imm(imm), .jump_target(jump_target),
    .reg_dst_rd(reg_dst_rd), .alu_src_imm(alu_src_imm), .alu_op(alu_op),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_wr(reg_wr),
    .mem_to_reg(mem_to_reg), .branch(branch), .jump(jump)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // control bundle order: dst, src, op[2:0], mrd, mwr, rwr, m2r, br, jmp
  function automatic logic [10:0] got_ctrl();
    return {reg_dst_rd, alu_src_imm, alu_op, mem_rd, mem_wr, reg_wr, mem_to_reg, branch, jump};
  endfunction

  function automatic logic [10:0] mk(bit d, bit s, logic [2:0] op, bit mr, bit mw,
                                     bit rw, bit m2r, bit br, bit j);
    return {d, s, op, mr, mw, rw, m2r, br, j};
  endfunction

  // Expected controls derived from the requirement text
  function automatic logic [10:0] expect_ctrl(logic [5:0] opc, logic [5:0] fn);
    case (opc)
      6'b000000: begin
        if (fn >= 6'b110000 && fn <= 6'b110110)
          return mk(1, 0, 3'(fn - 6'b110000), 0, 0, 1, 0, 0, 0);  // R2 R3
        return '0;                                               // R9
      end
      6'b001000: return mk(0, 1, 3'd0, 0, 0, 1, 0, 0, 0);         // R4
      6'b001001: return mk(0, 1, 3'd2, 0, 0, 1, 0, 0, 0);
      6'b001010: return mk(0, 1, 3'd3, 0, 0, 1, 0, 0, 0);
      6'b010000: return mk(0, 1, 3'd0, 1, 0, 1, 1, 0, 0);         // R5
      6'b010001: return mk(0, 1, 3'd0, 0, 1, 0, 0, 0, 0);         // R6
      6'b000100: return mk(0, 0, 3'd1, 0, 0, 0, 0, 1, 0);         // R7
      6'b000010: return mk(0, 0, 3'd0, 0, 0, 0, 0, 0, 1);         // R8
      default:   return '0;                                       // R9
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  typedef struct packed {
    logic [31:0] word;
    logic [10:0] ctrl;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0043_0830, 11'b1_0_000_0_0_1_0_0_0},  // R3 add
    '{32'h0043_0831, 11'b1_0_001_0_0_1_0_0_0},  // R2 sub
    '{32'h0043_0832, 11'b1_0_010_0_0_1_0_0_0},  // R2 and
    '{32'h0043_0833, 11'b1_0_011_0_0_1_0_0_0},  // R2 or
    '{32'h0043_0834, 11'b1_0_100_0_0_1_0_0_0},  // R2 nor
    '{32'h0003_0A75, 11'b1_0_101_0_0_1_0_0_0},  // R2 sll
    '{32'h0003_0A76, 11'b1_0_110_0_0_1_0_0_0},  // R2 srl
    '{32'h2022_0064, 11'b0_1_000_0_0_1_0_0_0},  // R4 addi
    '{32'h2422_00FF, 11'b0_1_010_0_0_1_0_0_0},  // R4 andi
    '{32'h2822_8001, 11'b0_1_011_0_0_1_0_0_0},  // R4 ori
    '{32'h4022_0010, 11'b0_1_000_1_0_1_1_0_0},  // R5 load
    '{32'h4422_0010, 11'b0_1_000_0_1_0_0_0_0},  // R6 store
    '{32'h1022_FFFE, 11'b0_0_001_0_0_0_0_1_0},  // R7 beq
    '{32'h0800_1234, 11'b0_0_000_0_0_0_0_0_1}   // R8 jump
  };

  initial begin
    instr = 32'h0;
    #1;
    // Quiet word at start (all-zero word has an unlisted function code), R9
    check("R9 zero word", 64'(got_ctrl()), 64'(11'b0));

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].word);
      check("R2-table", 64'(got_ctrl()), 64'(VECS[i].ctrl));
    end

    // R1 field positions on non-register words
    apply(32'hB5AC_E6F3);
    check("R1 rs", 64'(rs_idx), 64'(5'b01101));
    check("R1 rt", 64'(rt_idx), 64'(5'b01100));
    check("R1 rd", 64'(rd_idx), 64'(5'b11100));
    check("R1 shamt", 64'(shamt), 64'(5'b11011));
    check("R1 imm", 64'(imm), 64'(16'hE6F3));
    check("R1 target", 64'(jump_target), 64'(26'h1ACE6F3));
    check("R9 unknown opc 101101", 64'(got_ctrl()), 64'(11'b0));

    // R8 vs R7: jump with fields that look like a branch
    apply({6'b000010, 26'h3FF_FFFF});
    check("R8 jump only", 64'(got_ctrl()), 64'(mk(0, 0, 0, 0, 0, 0, 0, 0, 1)));
    check("R1 jump target all ones", 64'(jump_target), 64'(26'h3FF_FFFF));

    // Full opcode sweep with a legal function code, R9
    for (int op = 0; op < 64; op++) begin
      apply({6'(op), 5'd3, 5'd4, 5'd5, 5'd0, 6'b110001});
      check("R9 opcode sweep", 64'(got_ctrl()), 64'(expect_ctrl(6'(op), 6'b110001)));
    end

    // Full function sweep under opcode 000000, R2 R9
    for (int fn = 0; fn < 64; fn++) begin
      apply({6'b000000, 5'd1, 5'd2, 5'd3, 5'd7, 6'(fn)});
      check("R9 funct sweep", 64'(got_ctrl()), 64'(expect_ctrl(6'b000000, 6'(fn))));
    end

    // R10: output follows input without a clock edge
    @(negedge clk);
    instr = 32'h4422_0000;
    #0.5;
    check("R10 store immediate", 64'(mem_wr), 64'(1'b1));
    instr = 32'h4022_0000;
    #0.5;
    check("R10 load immediate", 64'({mem_rd, mem_wr}), 64'(2'b10));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule